// File: doc/BRIEF.md
# Region-Selectable Raster Frame Timer

This block produces the raster timing for a tile-based video processor. It is advanced by a single dot-clock enable. It keeps a dot counter and a scanline counter, and it moves every frame through four phases in a fixed order: the visible picture, an idle stretch after the picture, vertical blanking, and one pre-render scanline. It reports the current position and which phase is active. It also raises a one-enable interrupt pulse where vertical blanking begins, holds a blanking flag, and keeps an odd/even frame flag.

A two-bit region select picks one of three frame shapes: one 60 Hz layout and two 50 Hz layouts. The two 50 Hz layouts place the blanking interrupt at different distances after the picture. When rendering is enabled in the 60 Hz layout, every odd frame is one dot shorter. The region is captured only at reset and at the frame wrap, so one frame never mixes two layouts. All lengths are parameters. The defaults are 341 dots per line and 240 picture lines.

Top module: `frame_timer`

## Requirements
- R1: Each scanline holds DOTS_PER_LINE dots (default 341), numbered 0 to DOTS_PER_LINE-1. `dot` rises by one on each cycle with `dotEn` high and wraps to 0 after the last dot.
- R2: In every region, lines 0 to PICTURE_LINES-1 (default 239) form the picture. The post-render lines follow, then the blanking lines, then a single pre-render line, which is the last line of the frame. After the pre-render line, `line` wraps to 0. Exactly one of `inPicture`, `inPostRender`, `inVblank`, `inPreRender` is high at any time.
- R3: The region encodings are as follows. `regionSel`=00 and 11 give 1 post-render line and 20 blanking lines (262 lines, pre-render line 261). 01 gives 1 post-render line and 70 blanking lines (312 lines, pre-render line 311). 10 gives 51 post-render lines and 20 blanking lines (312 lines, pre-render line 311).
- R4: `vblankIrq` is high only at dot 1 of the first blanking line (line 241 for 00/01/11, line 291 for 10). It lasts for exactly one enabled cycle.
- R5: `vblankFlag` rises together with `vblankIrq`. It stays high through dot 0 of the pre-render line and is low from dot 1 of the pre-render line.
- R6: In regions 00/11, on an odd frame with `renderEn` high, the pre-render line ends at dot DOTS_PER_LINE-2 and is followed directly by dot 0 of line 0. Such a frame is 89341 dots long; every other frame in these regions is 89342 dots.
- R7: Regions 01 and 10 never skip a dot. Every frame is 106392 dots long, whatever `renderEn` is.
- R8: `oddFrame` toggles at every wrap from the pre-render line to line 0. It is 0 after reset.
- R9: `regionSel` is captured only during reset and at the frame wrap. A change in mid-frame takes effect from the next frame.
- R10: While `rst` is high at a clock edge, the block loads dot 0, line 0, `oddFrame`=0 and `vblankFlag`=0.
- R11: When `dotEn` is low, `dot`, `line`, `oddFrame` and `vblankFlag` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dotEn | input | 1 | Dot-clock enable; one dot per enabled cycle |
| regionSel | input | 2 | Region layout select (see R3) |
| renderEn | input | 1 | Rendering active; allows the odd-frame dot skip |
| dot | output | DOT_W (9) | Current dot within the line |
| line | output | LINE_W (9) | Current scanline |
| inPicture | output | 1 | Picture phase |
| inPostRender | output | 1 | Post-render idle phase |
| inVblank | output | 1 | Vertical blanking phase |
| inPreRender | output | 1 | Pre-render line |
| vblankIrq | output | 1 | Blanking-start interrupt pulse |
| vblankFlag | output | 1 | Blanking flag |
| oddFrame | output | 1 | Frame parity, 1 on odd frames |

## Verification
A wrong latched region or a wrong line decode moves the interrupt line and the pre-render line, and the very first frame after reset shows it in the measured frame length and interrupt position. A wrong parity register appears one frame later, as a 60 Hz frame of the wrong length or as a skip in a 50 Hz region. An enable leak shows up within one cycle as a counter that moves while `dotEn` is low. The bench measures whole frames in every region with and without rendering. It runs full default-size frames for the 60 Hz layout and for the long post-render layout, and it drives a mid-frame region change and a stalled interrupt.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;

  typedef enum logic [1:0] {
    REGION_60     = 2'b00,
    REGION_50     = 2'b01,
    REGION_50_ALT = 2'b10,
    REGION_60_B   = 2'b11
  } region_t;

  // Strobes from control to the counter datapath
  typedef struct packed {
    logic advance;
    logic lineEnd;
    logic frameEnd;
  } step_t;

endpackage

// File: rtl/frame_ctr.sv
module frame_ctr #(
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst,
  input  frame_timer_pkg::step_t   step,
  output logic [DOT_W-1:0]         dot,
  output logic [LINE_W-1:0]        line
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dot  <= '0;
      line <= '0;
    end else if (step.advance) begin
      if (step.frameEnd) begin
        dot  <= '0;
        line <= '0;
      end else if (step.lineEnd) begin
        dot  <= '0;
        line <= line + LINE_W'(1);
      end else begin
        dot  <= dot + DOT_W'(1);
      end
    end
  end

endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import frame_timer_pkg::*;
#(
  parameter int DOTS_PER_LINE      = 341,
  parameter int PICTURE_LINES      = 240,
  parameter int POST_LINES_SHORT   = 1,
  parameter int POST_LINES_LONG    = 51,
  parameter int VBLANK_LINES_SHORT = 20,
  parameter int VBLANK_LINES_LONG  = 70,
  parameter int DOT_W              = 9,
  parameter int LINE_W             = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dotEn,
  input  logic [1:0]        regionSel,
  input  logic              renderEn,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  output step_t             step,
  output logic              inPicture,
  output logic              inPostRender,
  output logic              inVblank,
  output logic              inPreRender,
  output logic              vblankIrq,
  output logic              vblankFlag,
  output logic              oddFrame
);

  localparam logic [DOT_W-1:0]  LAST_DOT = DOT_W'(DOTS_PER_LINE - 1);
  localparam logic [DOT_W-1:0]  SKIP_DOT = DOT_W'(DOTS_PER_LINE - 2);
  localparam logic [LINE_W-1:0] PIC_END  = LINE_W'(PICTURE_LINES);

  region_t           regionQ;
  logic              oddQ;
  logic              vblQ;
  logic [LINE_W-1:0] postLen;
  logic [LINE_W-1:0] vblLen;
  logic [LINE_W-1:0] vbStart;
  logic [LINE_W-1:0] preLine;
  logic              is60;
  logic              skipNow;
  logic              onVbStart;
  logic              onPreLine;

  // Per-region phase lengths
  always_comb begin
    unique case (regionQ)
      REGION_50: begin
        postLen = LINE_W'(POST_LINES_SHORT);
        vblLen  = LINE_W'(VBLANK_LINES_LONG);
      end
      REGION_50_ALT: begin
        postLen = LINE_W'(POST_LINES_LONG);
        vblLen  = LINE_W'(VBLANK_LINES_SHORT);
      end
      default: begin
        postLen = LINE_W'(POST_LINES_SHORT);
        vblLen  = LINE_W'(VBLANK_LINES_SHORT);
      end
    endcase
    is60    = (regionQ == REGION_60) || (regionQ == REGION_60_B);
    vbStart = PIC_END + postLen;
    preLine = vbStart + vblLen;
  end

  assign onVbStart = (line == vbStart);
  assign onPreLine = (line == preLine);

  // Step decision: the short pre-render line ends one dot early
  always_comb begin
    skipNow       = is60 && oddQ && renderEn && onPreLine;
    step.advance  = dotEn;
    step.lineEnd  = (dot == LAST_DOT) || (skipNow && dot == SKIP_DOT);
    step.frameEnd = step.lineEnd && onPreLine;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regionQ <= region_t'(regionSel);
      oddQ    <= 1'b0;
      vblQ    <= 1'b0;
    end else if (dotEn) begin
      if (step.frameEnd) begin
        regionQ <= region_t'(regionSel);
        oddQ    <= ~oddQ;
      end
      if (onVbStart && dot == '0) begin
        vblQ <= 1'b1;
      end else if (onPreLine && dot == '0) begin
        vblQ <= 1'b0;
      end
    end
  end

  assign inPicture    = (line < PIC_END);
  assign inPostRender = (line >= PIC_END) && (line < vbStart);
  assign inVblank     = (line >= vbStart) && (line < preLine);
  assign inPreRender  = onPreLine;
  assign vblankIrq    = onVbStart && (dot == DOT_W'(1));
  assign vblankFlag   = vblQ;
  assign oddFrame     = oddQ;

endmodule

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int DOTS_PER_LINE      = 341,
  parameter int PICTURE_LINES      = 240,
  parameter int POST_LINES_SHORT   = 1,
  parameter int POST_LINES_LONG    = 51,
  parameter int VBLANK_LINES_SHORT = 20,
  parameter int VBLANK_LINES_LONG  = 70,
  localparam int SPAN_A    = POST_LINES_SHORT + VBLANK_LINES_LONG,
  localparam int SPAN_B    = POST_LINES_LONG + VBLANK_LINES_SHORT,
  localparam int MAX_LINES = PICTURE_LINES + ((SPAN_A > SPAN_B) ? SPAN_A : SPAN_B) + 1,
  localparam int DOT_W     = $clog2(DOTS_PER_LINE),
  localparam int LINE_W    = $clog2(MAX_LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dotEn,
  input  logic [1:0]        regionSel,
  input  logic              renderEn,
  output logic [DOT_W-1:0]  dot,
  output logic [LINE_W-1:0] line,
  output logic              inPicture,
  output logic              inPostRender,
  output logic              inVblank,
  output logic              inPreRender,
  output logic              vblankIrq,
  output logic              vblankFlag,
  output logic              oddFrame
);

  frame_timer_pkg::step_t step;

  frame_ctrl #(
    .DOTS_PER_LINE(DOTS_PER_LINE),
    .PICTURE_LINES(PICTURE_LINES),
    .POST_LINES_SHORT(POST_LINES_SHORT),
    .POST_LINES_LONG(POST_LINES_LONG),
    .VBLANK_LINES_SHORT(VBLANK_LINES_SHORT),
    .VBLANK_LINES_LONG(VBLANK_LINES_LONG),
    .DOT_W(DOT_W),
    .LINE_W(LINE_W)
  ) ctrl (
    .clk(clk), .rst(rst), .dotEn(dotEn), .regionSel(regionSel),
    .renderEn(renderEn), .dot(dot), .line(line), .step(step),
    .inPicture(inPicture), .inPostRender(inPostRender),
    .inVblank(inVblank), .inPreRender(inPreRender),
    .vblankIrq(vblankIrq), .vblankFlag(vblankFlag), .oddFrame(oddFrame)
  );

  frame_ctr #(
    .DOT_W(DOT_W),
    .LINE_W(LINE_W)
  ) ctr (
    .clk(clk), .rst(rst), .step(step), .dot(dot), .line(line)
  );

endmodule

// File: rtl/frame_timer_chk.sv
module frame_timer_chk #(
  parameter int DOTS   = 341,
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              dotEn,
  input logic [DOT_W-1:0]  dot,
  input logic [LINE_W-1:0] line,
  input logic              inPicture,
  input logic              inPostRender,
  input logic              inVblank,
  input logic              inPreRender,
  input logic              vblankIrq,
  input logic              vblankFlag,
  input logic              oddFrame
);

  // R1
  dot_range_chk: assert property (@(posedge clk) disable iff (rst)
    dot <= DOT_W'(DOTS - 1));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !dotEn |=> $stable(dot) && $stable(line) && $stable(oddFrame) && $stable(vblankFlag));

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({inPicture, inPostRender, inVblank, inPreRender}) == 1);

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    dotEn && inPreRender && dot == DOT_W'(DOTS - 1) |=> dot == '0 && line == '0);

  // R4
  irq_pos_chk: assert property (@(posedge clk) disable iff (rst)
    vblankIrq |-> dot == DOT_W'(1) && inVblank);

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    vblankIrq && dotEn |=> !vblankIrq);

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vblankFlag) |-> vblankIrq);

  // R5
  flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vblankFlag) |-> inPreRender && dot == DOT_W'(1));

  // R6
  skip_target_chk: assert property (@(posedge clk) disable iff (rst)
    dotEn && dot == DOT_W'(DOTS - 2) |=> dot == DOT_W'(DOTS - 1) || (dot == '0 && line == '0));

  // R8
  parity_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(oddFrame) |-> dot == '0 && line == '0);

endmodule

bind frame_timer frame_timer_chk #(
  .DOTS(DOTS_PER_LINE), .DOT_W(DOT_W), .LINE_W(LINE_W)
) chkInst (
  .clk(clk), .rst(rst), .dotEn(dotEn), .dot(dot), .line(line),
  .inPicture(inPicture), .inPostRender(inPostRender), .inVblank(inVblank),
  .inPreRender(inPreRender), .vblankIrq(vblankIrq), .vblankFlag(vblankFlag),
  .oddFrame(oddFrame)
);

// File: tb/frame_timer_test.sv
module frame_timer_test;

  // Scaled instance: 12 dots, 6 picture lines, post 1/6, blanking 2/7
  localparam int NV = 5;
  // region, renderEn, evenLen, oddLen, irqLine, preLine, flagCount
  localparam int VEC [NV][7] = '{
    '{0, 1, 120, 119,  7,  9, 24},
    '{0, 0, 120, 120,  7,  9, 24},
    '{1, 1, 180, 180,  7, 14, 84},
    '{2, 1, 180, 180, 12, 14, 24},
    '{3, 1, 120, 119,  7,  9, 24}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rstD = 1'b1;
  logic dotEn = 1'b1;
  logic [1:0] regionSel = 2'b00;
  logic renderEn = 1'b0;

  logic [3:0] dot, line;
  logic inPicture, inPostRender, inVblank, inPreRender, vblankIrq, vblankFlag, oddFrame;

  logic [8:0] aDot, aLine, bDot, bLine;
  logic aPic, aPost, aVbl, aPre, aIrq, aFlag, aOdd;
  logic bPic, bPost, bVbl, bPre, bIrq, bFlag, bOdd;

  int checks = 0;
  int fails = 0;
  bit dfltDone = 1'b0;

  always #4 clk = ~clk;

  frame_timer #(
    .DOTS_PER_LINE(12), .PICTURE_LINES(6), .POST_LINES_SHORT(1),
    .POST_LINES_LONG(6), .VBLANK_LINES_SHORT(2), .VBLANK_LINES_LONG(7)
  ) uut (
    .clk(clk), .rst(rst), .dotEn(dotEn), .regionSel(regionSel), .renderEn(renderEn),
    .dot(dot), .line(line), .inPicture(inPicture), .inPostRender(inPostRender),
    .inVblank(inVblank), .inPreRender(inPreRender), .vblankIrq(vblankIrq),
    .vblankFlag(vblankFlag), .oddFrame(oddFrame)
  );

  frame_timer dflt60 (
    .clk(clk), .rst(rstD), .dotEn(1'b1), .regionSel(2'b00), .renderEn(1'b1),
    .dot(aDot), .line(aLine), .inPicture(aPic), .inPostRender(aPost),
    .inVblank(aVbl), .inPreRender(aPre), .vblankIrq(aIrq),
    .vblankFlag(aFlag), .oddFrame(aOdd)
  );

  frame_timer dfltAlt (
    .clk(clk), .rst(rstD), .dotEn(1'b1), .regionSel(2'b10), .renderEn(1'b0),
    .dot(bDot), .line(bLine), .inPicture(bPic), .inPostRender(bPost),
    .inVblank(bVbl), .inPreRender(bPre), .vblankIrq(bIrq),
    .vblankFlag(bFlag), .oddFrame(bOdd)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step1();
    @(posedge clk);
    #1;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  // Steps from line 0 dot 0 until the position returns there
  task automatic runFrame(output int len, output int irqLine, output int irqCnt,
                          output int maxLine, output int flagCnt);
    len = 0; irqLine = -1; irqCnt = 0; maxLine = 0; flagCnt = 0;
    do begin
      step1();
      len++;
      if (vblankIrq) begin irqCnt++; irqLine = int'(line); end
      if (vblankFlag) flagCnt++;
      if (int'(line) > maxLine) maxLine = int'(line);
    end while (!(dot == 4'd0 && line == 4'd0) && len < 1000);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  // Full-size frames on the default instances
  initial begin
    int n = 0;
    bit done60 = 1'b0, doneAlt = 1'b0;
    int len60 = 0, lenAlt = 0, irq60 = -1, irqAlt = -1, max60 = 0, maxAlt = 0;
    repeat (2) @(posedge clk);
    #1;
    rstD = 1'b0;
    while (!(done60 && doneAlt) && n < 120000) begin
      step1();
      n++;
      if (!done60) begin
        if (aIrq) irq60 = int'(aLine);
        if (int'(aLine) > max60) max60 = int'(aLine);
        if (aDot == 9'd0 && aLine == 9'd0) begin done60 = 1'b1; len60 = n; end
      end
      if (!doneAlt) begin
        if (bIrq) irqAlt = int'(bLine);
        if (int'(bLine) > maxAlt) maxAlt = int'(bLine);
        if (bDot == 9'd0 && bLine == 9'd0) begin doneAlt = 1'b1; lenAlt = n; end
      end
    end
    chk("R6", "default 60Hz even frame length", len60, 89342);
    chk("R3", "default 60Hz pre-render line", max60, 261);
    chk("R4", "default 60Hz irq line", irq60, 241);
    chk("R7", "default alt 50Hz frame length", lenAlt, 106392);
    chk("R3", "default alt 50Hz pre-render line", maxAlt, 311);
    chk("R4", "default alt 50Hz irq line", irqAlt, 291);
    dfltDone = 1'b1;
  end

  // Scaled instance: vector table, then directed tests
  initial begin
    int len, irqLine, irqCnt, maxLine, flagCnt;
    #1;
    for (int v = 0; v < NV; v++) begin
      regionSel = 2'(VEC[v][0]);
      renderEn  = VEC[v][1] != 0;
      doReset();
      if (v == 0) begin
        // R10 reset state
        chk("R10", "reset dot", dot, 0);
        chk("R10", "reset line", line, 0);
        chk("R10", "reset oddFrame", oddFrame, 0);
        chk("R10", "reset vblankFlag", vblankFlag, 0);
        chk("R2", "reset inPicture", inPicture, 1);
      end
      runFrame(len, irqLine, irqCnt, maxLine, flagCnt);
      chk("R6/R7 even length", $sformatf("vec %0d", v), len, VEC[v][2]);
      chk("R4 irq line", $sformatf("vec %0d", v), irqLine, VEC[v][4]);
      chk("R4 irq count", $sformatf("vec %0d", v), irqCnt, 1);
      chk("R3 pre-render line", $sformatf("vec %0d", v), maxLine, VEC[v][5]);
      chk("R5 flag dots", $sformatf("vec %0d", v), flagCnt, VEC[v][6]);
      chk("R8 parity after wrap", $sformatf("vec %0d", v), oddFrame, 1);
      runFrame(len, irqLine, irqCnt, maxLine, flagCnt);
      chk("R6/R7 odd length", $sformatf("vec %0d", v), len, VEC[v][3]);
      chk("R8 parity second wrap", $sformatf("vec %0d", v), oddFrame, 0);
    end

    // R9: region change in mid-frame applies from next frame
    regionSel = 2'b00;
    renderEn  = 1'b0;
    doReset();
    repeat (20) step1();
    regionSel = 2'b10;
    runFrame(len, irqLine, irqCnt, maxLine, flagCnt);
    chk("R9", "frame length after mid-frame change", len + 20, 120);
    chk("R9", "pre-render line unchanged", maxLine, 9);
    runFrame(len, irqLine, irqCnt, maxLine, flagCnt);
    chk("R9", "next frame length", len, 180);
    chk("R9", "next frame irq line", irqLine, 12);

    // R11 / R4 / R5: stalled interrupt and flag boundary
    regionSel = 2'b00;
    doReset();
    while (!vblankIrq && line != 4'd15) step1();
    dotEn = 1'b0;
    repeat (3) step1();
    chk("R11", "dot held while disabled", dot, 1);
    chk("R11", "line held while disabled", line, 7);
    chk("R4", "irq held while disabled", vblankIrq, 1);
    dotEn = 1'b1;
    step1();
    chk("R4", "irq after one enable", vblankIrq, 0);
    chk("R5", "flag high after irq", vblankFlag, 1);
    while (!(line == 4'd9 && dot == 4'd0)) step1();
    chk("R5", "flag at pre-render dot 0", vblankFlag, 1);
    step1();
    chk("R5", "flag at pre-render dot 1", vblankFlag, 0);
    chk("R1", "dot count on pre-render", dot, 1);

    wait (dfltDone);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule